// File: doc/BRIEF.md
# Multiplexed Display Shift-Register Sequencer

This block feeds a chain of external shift registers that drive a multiplexed LED display. It is a transmit-only serial master: every transfer is a 16-bit word sent most significant bit first in SPI mode 3. The serial clock idles high, data changes on the falling edge and the registers capture it on the rising edge.

A single-cycle load request hands over several inputs: a 32-bit segment pattern, the index of the digit to light, a brightness flag, a small set of indicator LED bits, and a flag that asks for the auxiliary register to be refreshed. When that flag is set, the block first sends a computed auxiliary word and pulses the auxiliary latch strobe. It then sends the upper half of the pattern, then the lower half, and pulses the driver latch strobe. When the flag is clear, the auxiliary word and its strobe are left out. A done pulse marks the end of the sequence. While a sequence runs, the busy output is high and further load requests are ignored.

Top module: `disp_shift_seq`

## Requirements
- R1: The serial clock is high whenever the block is idle, including directly after reset.
- R2: Each word has 16 bits, sent MSB first. The data line changes only on a falling edge of the serial clock, and each bit is held across the following rising edge.
- R3: When the auxiliary refresh flag is set on load, exactly 48 bits go out: the auxiliary word, then data bits 31..16, then data bits 15..0.
- R4: When the auxiliary refresh flag is clear, exactly 32 bits go out: data bits 31..16, then data bits 15..0. No auxiliary latch pulse is issued.
- R5: Auxiliary word low byte: bit 7 equals the brightness flag (high current) and bit 6 is its inverse (low current). Bits 5..1 carry the LED state bits, with LED bit 0 at word bit 1. Bit 0 is 0.
- R6: Auxiliary word high byte: every bit is 1 except bit 8+digit, which is 0.
- R7: The auxiliary latch is a one-cycle high pulse. It is issued after the 16th rising serial clock edge of the auxiliary word and before the first falling edge of the next word, with the serial clock high.
- R8: The driver latch is a one-cycle high pulse. It is issued after the last rising edge of the lower data half, with the serial clock high, and busy is low from that cycle on.
- R9: A load request is accepted only while busy is low. A request made while busy changes neither the bits sent nor the number of sequences run.
- R10: Each word takes 33*(SCK_DIV/2)+2 clock cycles. The driver latch rises N times that many cycles after the clock edge that accepted the load, where N is 3 with the auxiliary word and 2 without it. SCK_DIV is the even divider, 4 by default.
- R11: The done output is high in exactly the cycle of the driver latch pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load request, sampled while idle |
| data_i | input | 32 | Segment pattern word |
| digit_i | input | 3 | Index of the active digit |
| bright_i | input | 1 | 1 selects high LED current, 0 selects low |
| leds_i | input | 5 | Indicator LED state bits |
| aux_i | input | 1 | Refresh the auxiliary register in this sequence |
| busy_o | output | 1 | Sequence in progress |
| sck_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data out |
| aux_latch_o | output | 1 | Auxiliary register latch strobe |
| drv_latch_o | output | 1 | Driver register latch strobe |
| done_o | output | 1 | End-of-sequence pulse |

## Verification
A wrong sequencer state shows up on the wire within one word time, about 68 cycles by default. A word that is skipped or repeated changes the bit count seen at the latch strobes. A wrong half-select shifts the received pattern by 16 bits. A wrong digit index or brightness mapping appears as a flipped bit in the first 16 bits received. A shifter timing fault moves a data change away from a falling clock edge, or moves a latch pulse off its expected cycle count, so the fault is visible at the first bit or at the first latch.

// File: rtl/disp_seq_pkg.sv
package disp_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_AUX  = 2'd1,
    SEQ_HI   = 2'd2,
    SEQ_LO   = 2'd3
  } seq_state_e;

  // Cycles one serial word occupies, counted between shifter starts.
  function automatic int word_cycles(input int word_w, input int half);
    return (2 * word_w + 1) * half + 2;
  endfunction

endpackage

// File: rtl/disp_spi_tx.sv
module disp_spi_tx #(
  parameter int WORD_W  = 16,
  parameter int SCK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              done_o
);
  localparam int HALF      = (SCK_DIV < 2) ? 1 : SCK_DIV / 2;
  localparam int HC_W      = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int LAST_STEP = 2 * WORD_W;
  localparam int ST_W      = $clog2(LAST_STEP + 1);

  logic              active;
  logic [HC_W-1:0]   hcnt;
  logic [ST_W-1:0]   step;
  logic [WORD_W-1:0] shreg;
  logic              half_tick;

  assign half_tick = active && (hcnt == HC_W'(HALF - 1));

  // Step even: falling edge, next bit out. Step odd: rising edge.
  // Final step: trailing hold with clock high, then done.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      hcnt   <= '0;
      step   <= '0;
      shreg  <= '0;
      sck_o  <= 1'b1;
      mosi_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !active) begin
        active <= 1'b1;
        hcnt   <= '0;
        step   <= '0;
        shreg  <= word_i;
      end else if (active) begin
        if (half_tick) begin
          hcnt <= '0;
          step <= step + 1'b1;
          if (step == ST_W'(LAST_STEP)) begin
            active <= 1'b0;
            done_o <= 1'b1;
          end else if (!step[0]) begin
            sck_o  <= 1'b0;
            mosi_o <= shreg[WORD_W-1];
            shreg  <= {shreg[WORD_W-2:0], 1'b0};
          end else begin
            sck_o <= 1'b1;
          end
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/disp_seq_ctrl.sv
module disp_seq_ctrl
  import disp_seq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DIGITS = 8,
  parameter int LED_W  = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_i,
  input  logic [2*WORD_W-1:0]       data_i,
  input  logic [$clog2(DIGITS)-1:0] digit_i,
  input  logic                      bright_i,
  input  logic [LED_W-1:0]          leds_i,
  input  logic                      aux_i,
  input  logic                      tx_done_i,
  output logic                      load_ok_o,
  output logic                      start_o,
  output logic [WORD_W-1:0]         word_o,
  output logic                      busy_o,
  output logic                      aux_latch_o,
  output logic                      drv_latch_o,
  output logic                      done_o
);
  localparam int DIGIT_W = $clog2(DIGITS);
  localparam int SEL_LSB = 8;

  seq_state_e          state;
  logic [2*WORD_W-1:0] data_q;
  logic [WORD_W-1:0]   aux_q;

  // Digit select lines active low, current range bits 7/6, LEDs from bit 1.
  function automatic logic [WORD_W-1:0] build_aux(
    input logic [DIGIT_W-1:0] dig,
    input logic               bright,
    input logic [LED_W-1:0]   leds
  );
    logic [WORD_W-1:0] w;
    w = '0;
    for (int i = 0; i < DIGITS; i++) begin
      w[SEL_LSB+i] = (dig != DIGIT_W'(i));
    end
    w[7]       = bright;
    w[6]       = !bright;
    w[LED_W:1] = leds;
    return w;
  endfunction

  assign load_ok_o = load_i && (state == SEQ_IDLE);
  assign busy_o    = (state != SEQ_IDLE);

  always_comb begin
    unique case (state)
      SEQ_AUX: word_o = aux_q;
      SEQ_HI:  word_o = data_q[2*WORD_W-1:WORD_W];
      SEQ_LO:  word_o = data_q[WORD_W-1:0];
      default: word_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SEQ_IDLE;
      data_q      <= '0;
      aux_q       <= '0;
      start_o     <= 1'b0;
      aux_latch_o <= 1'b0;
      drv_latch_o <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      start_o     <= 1'b0;
      aux_latch_o <= 1'b0;
      drv_latch_o <= 1'b0;
      done_o      <= 1'b0;
      unique case (state)
        SEQ_IDLE: if (load_ok_o) begin
          data_q  <= data_i;
          aux_q   <= build_aux(digit_i, bright_i, leds_i);
          state   <= aux_i ? SEQ_AUX : SEQ_HI;
          start_o <= 1'b1;
        end
        SEQ_AUX: if (tx_done_i) begin
          aux_latch_o <= 1'b1;
          state       <= SEQ_HI;
          start_o     <= 1'b1;
        end
        SEQ_HI: if (tx_done_i) begin
          state   <= SEQ_LO;
          start_o <= 1'b1;
        end
        SEQ_LO: if (tx_done_i) begin
          drv_latch_o <= 1'b1;
          done_o      <= 1'b1;
          state       <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/disp_shift_seq.sv
module disp_shift_seq #(
  parameter int WORD_W  = 16,
  parameter int DIGITS  = 8,
  parameter int LED_W   = 5,
  parameter int SCK_DIV = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_i,
  input  logic [2*WORD_W-1:0]       data_i,
  input  logic [$clog2(DIGITS)-1:0] digit_i,
  input  logic                      bright_i,
  input  logic [LED_W-1:0]          leds_i,
  input  logic                      aux_i,
  output logic                      busy_o,
  output logic                      sck_o,
  output logic                      mosi_o,
  output logic                      aux_latch_o,
  output logic                      drv_latch_o,
  output logic                      done_o
);
  // Internal events, named for the bound checker.
  logic              tx_start;
  logic              tx_done;
  logic              load_ok;
  logic [WORD_W-1:0] tx_word;

  disp_seq_ctrl #(
    .WORD_W (WORD_W),
    .DIGITS (DIGITS),
    .LED_W  (LED_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .data_i      (data_i),
    .digit_i     (digit_i),
    .bright_i    (bright_i),
    .leds_i      (leds_i),
    .aux_i       (aux_i),
    .tx_done_i   (tx_done),
    .load_ok_o   (load_ok),
    .start_o     (tx_start),
    .word_o      (tx_word),
    .busy_o      (busy_o),
    .aux_latch_o (aux_latch_o),
    .drv_latch_o (drv_latch_o),
    .done_o      (done_o)
  );

  disp_spi_tx #(
    .WORD_W  (WORD_W),
    .SCK_DIV (SCK_DIV)
  ) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (tx_start),
    .word_i  (tx_word),
    .sck_o   (sck_o),
    .mosi_o  (mosi_o),
    .done_o  (tx_done)
  );

endmodule

// File: rtl/disp_shift_seq_chk.sv
module disp_shift_seq_chk #(
  parameter int WORD_W = 16
) (
  input logic clk,
  input logic rst_n,
  input logic load_i,
  input logic aux_i,
  input logic load_ok,
  input logic tx_done,
  input logic busy_o,
  input logic sck_o,
  input logic mosi_o,
  input logic aux_latch_o,
  input logic drv_latch_o,
  input logic done_o
);
  localparam int CW = $clog2(3 * WORD_W + 1) + 1;

  logic          sck_q;
  logic          aux_req_q;
  logic [CW-1:0] rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q     <= 1'b1;
      aux_req_q <= 1'b0;
      rises     <= '0;
    end else begin
      sck_q <= sck_o;
      if (load_ok) begin
        rises     <= '0;
        aux_req_q <= aux_i;
      end else if (sck_o && !sck_q) begin
        rises <= rises + 1'b1;
      end
    end
  end

  p_sck_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> sck_o);

  p_mosi_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi_o) |-> $fell(sck_o));

  p_word_end_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> sck_o);

  p_aux_after_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    aux_latch_o |-> (rises == CW'(WORD_W)));

  p_aux_only_requested_r4: assert property (@(posedge clk) disable iff (!rst_n)
    aux_latch_o |-> aux_req_q);

  p_aux_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    aux_latch_o |=> !aux_latch_o);

  p_latch_sck_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_latch_o || drv_latch_o) |-> sck_o);

  p_drv_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drv_latch_o |-> (rises == (aux_req_q ? CW'(3 * WORD_W) : CW'(2 * WORD_W))));

  p_drv_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drv_latch_o |-> (!busy_o && $past(busy_o)));

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !tx_done) |=> busy_o);

  p_start_needs_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(load_i));

  p_done_with_drv_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> drv_latch_o);

  p_drv_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    drv_latch_o |-> done_o);

endmodule

bind disp_shift_seq disp_shift_seq_chk #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_i      (load_i),
  .aux_i       (aux_i),
  .load_ok     (load_ok),
  .tx_done     (tx_done),
  .busy_o      (busy_o),
  .sck_o       (sck_o),
  .mosi_o      (mosi_o),
  .aux_latch_o (aux_latch_o),
  .drv_latch_o (drv_latch_o),
  .done_o      (done_o)
);

// File: tb/disp_shift_seq_bench.sv
`timescale 1ns/1ps
module disp_shift_seq_bench;
  localparam int SCK_DIV  = 4;
  localparam int WORD_CYC = 33 * (SCK_DIV / 2) + 2;
  localparam int NVEC     = 6;

  // {aux, bright, digit[2:0], leds[4:0], data[31:0]}
  localparam logic [41:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 3'd0, 5'h15, 32'hA5C3_0F81},
    {1'b0, 1'b0, 3'd3, 5'h00, 32'h1234_5678},
    {1'b1, 1'b0, 3'd7, 5'h1F, 32'hFFFF_0000},
    {1'b1, 1'b1, 3'd4, 5'h0A, 32'h0000_FFFF},
    {1'b0, 1'b1, 3'd7, 5'h1F, 32'h8000_0001},
    {1'b1, 1'b0, 3'd2, 5'h01, 32'hDEAD_BEEF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic [31:0] data_i = '0;
  logic [2:0]  digit_i = '0;
  logic        bright_i = 1'b0;
  logic [4:0]  leds_i = '0;
  logic        aux_i = 1'b0;
  logic        busy_o, sck_o, mosi_o, aux_latch_o, drv_latch_o, done_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  disp_shift_seq #(.SCK_DIV(SCK_DIV)) u_disp_shift_seq (
    .clk (clk), .rst_n (rst_n), .load_i (load_i), .data_i (data_i),
    .digit_i (digit_i), .bright_i (bright_i), .leds_i (leds_i), .aux_i (aux_i),
    .busy_o (busy_o), .sck_o (sck_o), .mosi_o (mosi_o),
    .aux_latch_o (aux_latch_o), .drv_latch_o (drv_latch_o), .done_o (done_o)
  );

  // Receiver model: shift in on rising serial clock.
  bit          mon_en = 1'b0;
  logic [47:0] rx;
  int          nbits, aux_cnt, aux_at, drv_cnt, done_cnt, both_cnt;

  always @(posedge sck_o) begin
    if (mon_en) begin
      rx    = {rx[46:0], mosi_o};
      nbits = nbits + 1;
    end
  end

  always @(negedge clk) begin
    if (mon_en) begin
      if (aux_latch_o) begin aux_cnt++; aux_at = nbits; end
      if (drv_latch_o) drv_cnt++;
      if (done_o) done_cnt++;
      if (done_o && drv_latch_o) both_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_aux(input logic [2:0] dig, input logic br,
                                          input logic [4:0] leds);
    logic [15:0] w;
    w = {8'hFF, br, ~br, leds, 1'b0};
    w[8 + dig] = 1'b0;
    return w;
  endfunction

  task automatic run_seq(input logic aux, input logic br, input logic [2:0] dig,
                         input logic [4:0] leds, input logic [31:0] data,
                         input bit inject);
    int cnt;
    int n_words;
    logic [47:0] exp;
    @(negedge clk);
    rx = '0; nbits = 0; aux_cnt = 0; aux_at = -1; drv_cnt = 0; done_cnt = 0;
    both_cnt = 0;
    mon_en = 1'b1;
    load_i = 1'b1; data_i = data; digit_i = dig; bright_i = br; leds_i = leds;
    aux_i = aux;
    @(negedge clk);
    load_i = 1'b0;
    cnt = 1;
    while (!drv_latch_o && cnt < 2000) begin
      @(negedge clk);
      cnt++;
      if (inject && cnt == 90) begin
        load_i = 1'b1; data_i = ~data; aux_i = ~aux; digit_i = dig + 3'd1;
      end else if (inject && cnt == 91) begin
        load_i = 1'b0;
      end
    end
    n_words = aux ? 3 : 2;
    chk(cnt == n_words * WORD_CYC + 1, "R10 latency", 64'(cnt), 64'(n_words * WORD_CYC + 1));
    chk(!busy_o, "R8 busy low at driver latch", 64'(busy_o), 64'd0);
    repeat (6) @(negedge clk);
    if (inject) repeat (300) @(negedge clk);
    mon_en = 1'b0;
    exp = aux ? {exp_aux(dig, br, leds), data} : {16'h0, data};
    chk(nbits == n_words * 16, aux ? "R3 bit count" : "R4 bit count",
        64'(nbits), 64'(n_words * 16));
    chk(rx == exp, aux ? "R3 R5 R6 serial content" : "R4 serial content", 64'(rx), 64'(exp));
    chk(aux_cnt == (aux ? 1 : 0), "R7 aux latch pulse count", 64'(aux_cnt), 64'(aux ? 1 : 0));
    if (aux) chk(aux_at == 16, "R7 aux latch after 16 bits", 64'(aux_at), 64'd16);
    chk(drv_cnt == 1, "R8 driver latch one cycle", 64'(drv_cnt), 64'd1);
    chk(done_cnt == 1 && both_cnt == 1, "R11 done with driver latch",
        64'(done_cnt), 64'd1);
    chk(sck_o && !busy_o, "R1 idle clock high", 64'({sck_o, busy_o}), 64'h2);
    if (inject) chk(nbits == n_words * 16 && drv_cnt == 1, "R9 busy load ignored",
                    64'(nbits), 64'(n_words * 16));
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({sck_o, busy_o, aux_latch_o, drv_latch_o, done_o, mosi_o} == 6'b100000,
        "R1 reset state", 64'({sck_o, busy_o, aux_latch_o, drv_latch_o, done_o, mosi_o}),
        64'h20);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sck_o && !busy_o, "R1 idle after reset", 64'({sck_o, busy_o}), 64'h2);

    for (int i = 0; i < NVEC; i++) begin
      run_seq(VEC[i][41], VEC[i][40], VEC[i][39:37], VEC[i][36:32], VEC[i][31:0], 1'b0);
    end

    // R9: load pulsed mid-sequence, with and without aux refresh.
    run_seq(1'b1, 1'b1, 3'd5, 5'h13, 32'h0F0F_55AA, 1'b1);
    run_seq(1'b0, 1'b0, 3'd1, 5'h04, 32'hC001_D00D, 1'b1);

    // R2: single-bit-set and single-bit-clear patterns expose ordering.
    run_seq(1'b1, 1'b1, 3'd6, 5'h10, 32'h0001_8000, 1'b0);
    run_seq(1'b0, 1'b0, 3'd0, 5'h00, 32'hFFFE_7FFF, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule